// File: doc/BRIEF.md
# Next-PC Predictor with Target Table and Return Stack

This block sits in the fetch stage and guesses the address to fetch next. Each cycle it receives the current fetch address and a taken/not-taken guess from a separate direction predictor. It looks the address up in a small direct-mapped table of known control instructions. A hit supplies a stored target, or, for a return, the newest entry of a return stack. A miss falls through to the next sequential word.

The execute stage feeds resolved control instructions back through an update port. That port carries the instruction address, its real target, its class and a flag that says the earlier guess was wrong. Only wrong guesses allocate or rewrite a table entry. A table entry therefore appears after the instruction has executed once and been mispredicted.

Tags are deliberately short. Two addresses that agree in their index and tag bits share an entry, and the resulting wrong guess is repaired through the normal update path.

Top module: `npcPredictor`

## Requirements
- R1: After reset every table entry is invalid, so any fetch address reports no hit and predicts fetch address + 4.
- R2: A hit on an entry of class branch (code 0) with the direction input high predicts the stored target.
- R3: A hit on a branch-class entry with the direction input low predicts fetch address + 4 but still reports a hit.
- R4: A fetch address whose index selects an invalid entry, or an entry with a different tag, reports no hit and predicts fetch address + 4.
- R5: The index is fetch address bits [IDX_W+1:2] and the tag is the next TAG_W bits above it. Address bits above the tag are ignored, so aliasing addresses hit the same entry.
- R6: Address bits [1:0] take no part in index or tag.
- R7: Entries of class call (code 1) and jump (code 3) predict the stored target whatever the direction input says.
- R8: A valid fetch hitting a call entry pushes fetch address + 4 onto the return stack. A valid fetch hitting a return entry (code 2) predicts the newest stack value and pops it. The stored target and the direction input are ignored for returns, and nested calls unwind last-in first-out.
- R9: The return stack is circular with RAS_DEPTH slots (a power of two). A push beyond the depth overwrites the oldest value, and further pops keep wrapping.
- R10: An update writes the table only when both update valid and mispredict are high. The new contents are seen by fetches from the next cycle on.
- R11: A mispredict update replaces the tag, target and class of the entry it indexes in that one write.
- R12: With fetch valid low the return stack is neither pushed nor popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch address is real this cycle |
| fetchPc | input | PC_W | Current fetch address |
| predTaken | input | 1 | Direction guess for conditional branches |
| updValid | input | 1 | Resolved control instruction present |
| updPc | input | PC_W | Address of the resolved instruction |
| updTarget | input | PC_W | Actual target of the resolved instruction |
| updKind | input | 2 | Class: 0 branch, 1 call, 2 return, 3 jump |
| updMispredict | input | 1 | Earlier guess for this instruction was wrong |
| nextPc | output | PC_W | Predicted next fetch address |
| predHit | output | 1 | Fetch address matched a valid entry |

## Verification
The bench builds the block with IDX_W=3, TAG_W=4 and RAS_DEPTH=4. Eight entries and a four-bit tag mean two addresses 0x200 apart collide in index and tag, so a genuine false hit is easy to produce. A four-slot stack is overrun by five nested calls, which shows the oldest value being lost and the pointer wrapping on later pops. The small table also lets a different tag overwrite an existing entry at the same index.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_CALL   = 2'd1,
    KIND_RET    = 2'd2,
    KIND_JUMP   = 2'd3
  } npcKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic selRas;
    logic selTgt;
    logic wrEntry;
  } npcStrb_t;

endpackage

// File: rtl/npc_ctrl.sv
module npcCtrl
  import npc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             predTaken,
  input  logic             updValid,
  input  logic             updMispredict,
  input  logic             lkValid,
  input  logic [TAG_W-1:0] lkTag,
  input  npcKind_t         lkKind,
  output npcStrb_t         strb,
  output logic             hit
);

  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_HI = IDX_W + TAG_W + 1;

  logic [TAG_W-1:0] fetchTag;
  logic isCall, isRet, isBranch;

  assign fetchTag = fetchPc[TAG_HI:TAG_LO];
  assign hit      = lkValid && (lkTag == fetchTag);

  always_comb begin
    isCall   = hit && (lkKind == KIND_CALL);
    isRet    = hit && (lkKind == KIND_RET);
    isBranch = hit && (lkKind == KIND_BRANCH);
    strb         = '0;
    strb.push    = fetchValid && isCall;
    strb.pop     = fetchValid && isRet;
    strb.selRas  = isRet;
    strb.selTgt  = hit && !isRet && (!isBranch || predTaken);
    strb.wrEntry = updValid && updMispredict;
  end

  // R8: a single fetch never pushes and pops together
  assert_push_pop_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.pop}));

  // R12: no stack action without a valid fetch
  assert_idle_no_stack_R12: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !(strb.push || strb.pop));

endmodule

// File: rtl/npc_datapath.sv
module npcDatapath
  import npc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 8,
  parameter int RAS_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  npcKind_t         updKind,
  input  npcStrb_t         strb,
  output logic             lkValid,
  output logic [TAG_W-1:0] lkTag,
  output npcKind_t         lkKind,
  output logic [PC_W-1:0]  nextPc
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = IDX_W + 2;
  localparam int TAG_HI  = IDX_W + TAG_W + 1;
  localparam int RAS_PW  = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1;

  logic [ENTRIES-1:0] validBits;
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [PC_W-1:0]    tgtMem [ENTRIES];
  npcKind_t           kindMem[ENTRIES];

  logic [PC_W-1:0]    rasMem [RAS_DEPTH];
  logic [RAS_PW-1:0]  rasPtr;
  logic [PC_W-1:0]    rasTop;
  logic [PC_W-1:0]    pushData;
  logic [PC_W-1:0]    seqPc;

  logic [IDX_W-1:0]   fetchIdx, updIdx;

  assign fetchIdx = fetchPc[IDX_W+1:2];
  assign updIdx   = updPc[IDX_W+1:2];

  // table read
  assign lkValid = validBits[fetchIdx];
  assign lkTag   = tagMem[fetchIdx];
  assign lkKind  = kindMem[fetchIdx];

  // table write, one entry per mispredict
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strb.wrEntry) begin
      validBits[updIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEntry) begin
      tagMem[updIdx]  <= updPc[TAG_HI:TAG_LO];
      tgtMem[updIdx]  <= updTarget;
      kindMem[updIdx] <= updKind;
    end
  end

  // circular return stack
  assign seqPc    = fetchPc + PC_W'(4);
  assign pushData = seqPc;
  assign rasTop   = rasMem[rasPtr - RAS_PW'(1)];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPtr <= '0;
    end else if (strb.push) begin
      rasPtr <= rasPtr + RAS_PW'(1);
    end else if (strb.pop) begin
      rasPtr <= rasPtr - RAS_PW'(1);
    end
  end

  generate
    for (genvar s = 0; s < RAS_DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rasMem[s] <= '0;
        end else if (strb.push && (rasPtr == RAS_PW'(s))) begin
          rasMem[s] <= pushData;
        end
      end
    end
  endgenerate

  // next-PC select
  always_comb begin
    if (strb.selRas)      nextPc = rasTop;
    else if (strb.selTgt) nextPc = tgtMem[fetchIdx];
    else                  nextPc = seqPc;
  end

  // R8: a pushed return address is the new stack top
  assert_push_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> rasTop == $past(pushData));

  // R11: a mispredict write leaves the new target in its entry
  assert_write_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEntry |=> tgtMem[$past(updIdx)] == $past(updTarget));

  // R10: without a write the valid bits never change
  assert_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEntry |=> $stable(validBits));

  // R12: stack pointer holds when the stack is not touched
  assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push || strb.pop) |=> $stable(rasPtr));

endmodule

// File: rtl/npc_predictor.sv
module npcPredictor
  import npc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 8,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic [1:0]      updKind,
  input  logic            updMispredict,
  output logic [PC_W-1:0] nextPc,
  output logic            predHit
);

  npcStrb_t         strb;
  logic             lkValid;
  logic [TAG_W-1:0] lkTag;
  npcKind_t         lkKind;

  npcCtrl #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predTaken(predTaken), .updValid(updValid), .updMispredict(updMispredict),
    .lkValid(lkValid), .lkTag(lkTag), .lkKind(lkKind),
    .strb(strb), .hit(predHit)
  );

  npcDatapath #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .RAS_DEPTH(RAS_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updPc(updPc),
    .updTarget(updTarget), .updKind(npcKind_t'(updKind)), .strb(strb),
    .lkValid(lkValid), .lkTag(lkTag), .lkKind(lkKind), .nextPc(nextPc)
  );

  // R4: a miss always falls through to the sequential address
  assert_miss_seq_R4: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> nextPc == fetchPc + PC_W'(4));

endmodule

// File: tb/tb_npcPredictor.sv
module tb_npcPredictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 0, rstN = 0;
  logic fetchValid = 0, predTaken = 0;
  logic [PC_W-1:0] fetchPc = '0, updPc = '0, updTarget = '0;
  logic updValid = 0, updMispredict = 0;
  logic [1:0] updKind = 2'd0;
  logic [PC_W-1:0] nextPc;
  logic predHit;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [PC_W-1:0] pc; logic hit; string req; } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  npcPredictor #(.PC_W(PC_W), .IDX_W(3), .TAG_W(4), .RAS_DEPTH(4)) dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predTaken(predTaken), .updValid(updValid), .updPc(updPc),
    .updTarget(updTarget), .updKind(updKind), .updMispredict(updMispredict),
    .nextPc(nextPc), .predHit(predHit));

  // driver: one fetch per cycle, expectation queued
  task automatic fetch(input logic [PC_W-1:0] pc, input logic tk, input logic vld,
                       input logic chk, input logic [PC_W-1:0] ePc, input logic eHit,
                       input string req);
    exp_t e;
    @(negedge clk);
    updValid = 0; updMispredict = 0;
    fetchValid = vld; fetchPc = pc; predTaken = tk;
    if (chk) begin
      e.pc = ePc; e.hit = eHit; e.req = req;
      expQ.push_back(e);
    end
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                        input logic [1:0] kind, input logic mis);
    @(negedge clk);
    fetchValid = 0;
    updValid = 1; updPc = pc; updTarget = tgt; updKind = kind; updMispredict = mis;
  endtask

  // monitor: compare a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (nextPc !== e.pc || predHit !== e.hit) begin
          errors++;
          $display("FAIL %s: nextPc=%h hit=%b expected nextPc=%h hit=%b",
                   e.req, nextPc, predHit, e.pc, e.hit);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, everything misses
    fetch(32'h100, 1, 1, 1, 32'h104, 0, "R1");
    @(negedge clk); rstN = 1;
    fetch(32'h100, 1, 1, 1, 32'h104, 0, "R1");
    // R2/R3: branch entry
    update(32'h100, 32'h200, 2'd0, 1);
    fetch(32'h100, 1, 1, 1, 32'h200, 1, "R2");
    fetch(32'h100, 0, 1, 1, 32'h104, 1, "R3");
    // R5: alias above the tag bits
    fetch(32'h300, 1, 1, 1, 32'h200, 1, "R5");
    // R4: same index, other tag
    fetch(32'h120, 1, 1, 1, 32'h124, 0, "R4");
    // R6: low bits ignored
    fetch(32'h102, 1, 1, 1, 32'h200, 1, "R6");
    // R10: update without mispredict writes nothing
    update(32'h144, 32'h500, 2'd3, 0);
    fetch(32'h144, 1, 1, 1, 32'h148, 0, "R10");
    // R7: jump is unconditional
    update(32'h144, 32'h500, 2'd3, 1);
    fetch(32'h144, 0, 1, 1, 32'h500, 1, "R7");
    // calls and return entries
    update(32'h188, 32'h800, 2'd1, 1);
    update(32'h190, 32'h900, 2'd1, 1);
    update(32'h1B4, 32'hA00, 2'd1, 1);
    update(32'h84C, 32'h999, 2'd2, 1);
    // R7/R8: call with direction low still jumps, pushes 0x18C
    fetch(32'h188, 0, 1, 1, 32'h800, 1, "R7");
    // R12: invalid fetch of the return must not pop
    fetch(32'h84C, 0, 0, 0, 32'h0, 0, "R12");
    fetch(32'h84C, 0, 1, 1, 32'h18C, 1, "R12");
    // R8: nested unwind
    fetch(32'h188, 1, 1, 1, 32'h800, 1, "R8");
    fetch(32'h190, 1, 1, 1, 32'h900, 1, "R8");
    fetch(32'h84C, 1, 1, 1, 32'h194, 1, "R8");
    fetch(32'h84C, 1, 1, 1, 32'h18C, 1, "R8");
    // R9: five pushes into four slots
    fetch(32'h188, 1, 1, 1, 32'h800, 1, "R9");
    fetch(32'h190, 1, 1, 1, 32'h900, 1, "R9");
    fetch(32'h1B4, 1, 1, 1, 32'hA00, 1, "R9");
    fetch(32'h188, 1, 1, 1, 32'h800, 1, "R9");
    fetch(32'h190, 1, 1, 1, 32'h900, 1, "R9");
    fetch(32'h84C, 0, 1, 1, 32'h194, 1, "R9");
    fetch(32'h84C, 0, 1, 1, 32'h18C, 1, "R9");
    fetch(32'h84C, 0, 1, 1, 32'h1B8, 1, "R9");
    fetch(32'h84C, 0, 1, 1, 32'h194, 1, "R9");
    fetch(32'h84C, 0, 1, 1, 32'h194, 1, "R9");
    // R11: rewrite class/target, then tag
    update(32'h100, 32'h300, 2'd3, 1);
    fetch(32'h100, 0, 1, 1, 32'h300, 1, "R11");
    update(32'h120, 32'h700, 2'd0, 1);
    fetch(32'h100, 1, 1, 1, 32'h104, 0, "R11");
    fetch(32'h120, 1, 1, 1, 32'h700, 1, "R11");
    fetch(32'h0, 0, 0, 0, 32'h0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule